// File: doc/BRIEF.md
# Sequence Digit Display Controller

The block takes a fast system clock and derives a one-second step pulse from it. Each pulse moves a Moore machine one place along the fixed digit code 8, 7, 0, 1, 0, 7. After the last 7 the machine goes back to 8. A 4-bit pass counter records how many full runs of the code have finished.

The current code digit and the pass count share one seven-segment segment bus across two display positions. A free-running refresh counter drives a 1-to-2 select decoder. The decoder's select also steers a 2-to-1 digit multiplexer, so the two positions are lit in turn, fast enough that both appear steady.

Every register runs on the system clock and is qualified by enables; the design uses no divided clock. Reset is asserted asynchronously and is released through an internal two-stage synchronizer.

Top module: `seqdisp_top`

## Requirements
- R1: A step pulse lasting one clock cycle occurs once every DIV_LAST+1 clock cycles that the block is out of reset; the default is 50,000,000, which gives 1 Hz at 50 MHz. The code digit changes only on a step pulse.
- R2: After reset, the code position shows 8 and the pass count is 0.
- R3: Successive step pulses move the code digit through 8, 7, 0, 1, 0, 7. The pulse that follows the last 7 returns it to 8.
- R4: The pass count increases by one on the step pulse that moves the digit from the last 7 to 8, and at no other time. So it reads 0 during the first run, 1 during the second, and so on.
- R5: The pass count wraps from 15 to 0. Values 10 to 15 are displayed as the hexadecimal glyphs A to F.
- R6: The anode outputs are active-low, and exactly one of them is low at any time. When an_n = 2'b10 (bit 0 low), the segment bus carries the code digit. When an_n = 2'b01, it carries the pass count.
- R7: The scan select is bit REF_BIT of a refresh counter that clears on reset. It therefore changes every 2^REF_BIT cycles out of reset, and an_n starts at 2'b10.
- R8: Segments are active-high in the order gfedcba, with seg[0] = a. The codes for hex 0 to F are: 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F, 77, 7C, 39, 5E, 79, 71.
- R9: Driving rst_n low resets the block at once. After rst_n rises, counting begins on the third rising clock edge; the first two edges leave the reset state in place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| an_n | output | 2 | Active-low position selects; bit 0 is the code digit, bit 1 is the pass count |
| seg | output | 7 | Segment lines, gfedcba, active-high |

## Verification
Both display outputs are decoded from registers, so any change shows up in the same clock edge that updates a register. The bench counts rising edges n after reset release and takes m = n - 2 (floored at zero) as the number of counting cycles, accounting for the two synchronizer stages. From m it computes the due values: the code index is (m / (DIV_LAST+1)) mod 6, the pass count is that quotient divided by 6, mod 16, and the select is bit REF_BIT of m. It samples on the falling edge after each rising edge, never at the edge itself. Reset checks are sampled 1 ns after rst_n falls, because assertion takes effect at once.

// File: rtl/seqdisp_pkg.sv
package seqdisp_pkg;

  localparam int DIG_W = 4;
  localparam int SEG_W = 7;

  typedef enum logic [2:0] {
    ST_EIGHT  = 3'd0,
    ST_SEVEN1 = 3'd1,
    ST_ZERO1  = 3'd2,
    ST_ONE    = 3'd3,
    ST_ZERO2  = 3'd4,
    ST_SEVEN2 = 3'd5
  } code_st_t;

  // hex value to gfedcba glyph, active-high, bit 0 = segment a
  function automatic logic [SEG_W-1:0] hex_glyph(input logic [DIG_W-1:0] v);
    logic [SEG_W-1:0] g;
    case (v)
      4'h0: g = 7'h3F;
      4'h1: g = 7'h06;
      4'h2: g = 7'h5B;
      4'h3: g = 7'h4F;
      4'h4: g = 7'h66;
      4'h5: g = 7'h6D;
      4'h6: g = 7'h7D;
      4'h7: g = 7'h07;
      4'h8: g = 7'h7F;
      4'h9: g = 7'h6F;
      4'hA: g = 7'h77;
      4'hB: g = 7'h7C;
      4'hC: g = 7'h39;
      4'hD: g = 7'h5E;
      4'hE: g = 7'h79;
      default: g = 7'h71;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int DIV_LAST = 49_999_999,
  localparam int CW = $clog2(DIV_LAST + 1)
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_end;

  assign at_end = (cnt_q == CW'(DIV_LAST));

  always_comb begin
    if (at_end) cnt_d = '0;
    else        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = at_end;

endmodule

// File: rtl/code_seq.sv
module code_seq
  import seqdisp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [DIG_W-1:0] digit,
  output logic             wrap
);

  code_st_t st_q, st_d;

  // next-state
  always_comb begin
    st_d = st_q;
    if (step) begin
      case (st_q)
        ST_EIGHT:  st_d = ST_SEVEN1;
        ST_SEVEN1: st_d = ST_ZERO1;
        ST_ZERO1:  st_d = ST_ONE;
        ST_ONE:    st_d = ST_ZERO2;
        ST_ZERO2:  st_d = ST_SEVEN2;
        default:   st_d = ST_EIGHT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_EIGHT;
    else        st_q <= st_d;
  end

  // Moore output
  always_comb begin
    case (st_q)
      ST_EIGHT:  digit = 4'd8;
      ST_SEVEN1: digit = 4'd7;
      ST_ZERO1:  digit = 4'd0;
      ST_ONE:    digit = 4'd1;
      ST_ZERO2:  digit = 4'd0;
      default:   digit = 4'd7;
    endcase
  end

  assign wrap = step && (st_q == ST_SEVEN2);

endmodule

// File: rtl/pass_counter.sv
module pass_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/scan_mux.sv
module scan_mux
  import seqdisp_pkg::*;
#(
  parameter int REF_BIT = 15,
  localparam int RW = REF_BIT + 1,
  localparam int NPOS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIG_W-1:0] code_val,
  input  logic [DIG_W-1:0] pass_val,
  output logic [NPOS-1:0]  an_n,
  output logic [SEG_W-1:0] seg
);

  logic [RW-1:0]    ref_q, ref_d;
  logic             sel;
  logic [NPOS-1:0]  dec;
  logic [DIG_W-1:0] shown;

  always_comb ref_d = ref_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= '0;
    else        ref_q <= ref_d;
  end

  assign sel = ref_q[REF_BIT];

  // 1-to-2 decoder
  for (genvar i = 0; i < NPOS; i++) begin : g_dec
    assign dec[i] = (sel == 1'(i));
  end

  assign an_n = ~dec;

  // 2-to-1 digit multiplexer, same select
  always_comb begin
    if (sel) shown = pass_val;
    else     shown = code_val;
  end

  assign seg = hex_glyph(shown);

endmodule

// File: rtl/seqdisp_top.sv
module seqdisp_top
  import seqdisp_pkg::*;
#(
  parameter int DIV_LAST = 49_999_999,
  parameter int REF_BIT  = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [1:0] an_n,
  output logic [6:0] seg
);

  logic             rst_q;
  logic             tick;
  logic             wrap;
  logic [DIG_W-1:0] code_digit;
  logic [DIG_W-1:0] pass_val;

  rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q)
  );

  tick_gen #(.DIV_LAST(DIV_LAST)) u_tick (
    .clk   (clk),
    .rst_n (rst_q),
    .tick  (tick)
  );

  code_seq u_seq (
    .clk   (clk),
    .rst_n (rst_q),
    .step  (tick),
    .digit (code_digit),
    .wrap  (wrap)
  );

  pass_counter #(.W(DIG_W)) u_pass (
    .clk   (clk),
    .rst_n (rst_q),
    .inc   (wrap),
    .count (pass_val)
  );

  scan_mux #(.REF_BIT(REF_BIT)) u_scan (
    .clk      (clk),
    .rst_n    (rst_q),
    .code_val (code_digit),
    .pass_val (pass_val),
    .an_n     (an_n),
    .seg      (seg)
  );

endmodule

// File: rtl/seqdisp_chk.sv
module seqdisp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wrap,
  input logic [3:0] digit,
  input logic [3:0] pass,
  input logic [1:0] an_n
);

  a_r1_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  a_r1_digit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(digit));

  a_r3_eight_to_seven: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && digit == 4'd8) |=> digit == 4'd7);

  a_r3_wrap_to_eight: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> digit == 4'd8);

  a_r4_pass_inc: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> pass == 4'($past(pass) + 1'b1));

  a_r4_pass_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(pass));

  a_r6_one_anode: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(an_n) == 1);

endmodule

bind seqdisp_top seqdisp_chk u_chk (
  .clk   (clk),
  .rst_n (rst_q),
  .tick  (tick),
  .wrap  (wrap),
  .digit (code_digit),
  .pass  (pass_val),
  .an_n  (an_n)
);

// File: tb/sim_seqdisp_top.sv
`timescale 1ns/1ps
module sim_seqdisp_top;

  localparam int CLK_PERIOD = 20;
  localparam int SIM_DIV    = 3;
  localparam int SIM_REF    = 1;
  localparam int STEP       = SIM_DIV + 1;

  localparam logic [3:0] CODE_TAB [6]  = '{4'd8, 4'd7, 4'd0, 4'd1, 4'd0, 4'd7};
  localparam logic [6:0] SEG_TAB  [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D,
                                           7'h7D, 7'h07, 7'h7F, 7'h6F, 7'h77, 7'h7C,
                                           7'h39, 7'h5E, 7'h79, 7'h71};

  logic       clk;
  logic       rst_n;
  logic [1:0] an_n;
  logic [6:0] seg;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  seqdisp_top #(.DIV_LAST(SIM_DIV), .REF_BIT(SIM_REF)) u0 (
    .clk   (clk),
    .rst_n (rst_n),
    .an_n  (an_n),
    .seg   (seg)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // n = rising edges since rst_n rose; two go to the synchronizer
  task automatic check_edge(input int n);
    int m, ticks, idx, pass;
    logic sel;
    logic [6:0] exp_seg;
    m     = (n > 2) ? n - 2 : 0;
    ticks = m / STEP;
    idx   = ticks % 6;
    pass  = (ticks / 6) % 16;
    sel   = 1'((m >> SIM_REF) & 1);
    if (n <= 2) begin
      chk("R9 anode held in reset", {5'd0, an_n}, 7'b10);
      chk("R9 seg held in reset", seg, SEG_TAB[8]);
    end else begin
      chk("R6 R7 anode select", {5'd0, an_n}, sel ? 7'b01 : 7'b10);
      exp_seg = sel ? SEG_TAB[pass] : SEG_TAB[CODE_TAB[idx]];
      if (sel) chk(pass >= 10 ? "R5 R8 pass glyph" : "R4 R8 pass glyph", seg, exp_seg);
      else     chk("R1 R3 R8 code glyph", seg, exp_seg);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 reset anode", {5'd0, an_n}, 7'b10);
    chk("R2 reset shows 8", seg, SEG_TAB[8]);
    rst_n = 1'b1;
    // walks past 16 full passes, so the 15 -> 0 wrap is covered
    for (int n = 1; n <= 2 + 16*6*STEP + 20; n++) begin
      @(posedge clk);
      @(negedge clk);
      check_edge(n);
    end
    // mid-run reset: asynchronous effect
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 async reset anode", {5'd0, an_n}, 7'b10);
    chk("R2 R9 async reset shows 8", seg, SEG_TAB[8]);
    @(negedge clk);
    rst_n = 1'b1;
    for (int n = 1; n <= 60; n++) begin
      @(posedge clk);
      @(negedge clk);
      check_edge(n);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog expired: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule